// File: doc/BRIEF.md
# Paged 16-bit Multicycle Processor Core

This core executes a compact 16-bit instruction set on a word-addressed machine with eight general registers, a program counter and a negative/zero/positive condition code. Every instruction is one 16-bit word. The core fetches it, decodes it and executes it over several clock cycles. All traffic goes through one synchronous memory port. Read data returns in the cycle after the address is presented, and a write takes effect at the clock edge that closes the cycle in which the write enable is high.

Direct loads, stores, branches, calls and address-forming instructions build their target by keeping the page bits of the already incremented PC and replacing its low nine bits with the instruction's offset field. No adder is involved. Register-based accesses add a small unsigned offset to a base register. Calls and traps save their return point in R7. Trap handlers are ordinary code, and their addresses are held in a vector table in the lowest 256 words. One trap vector is reserved to stop the machine.

Top module: `cpu16_core`

## Requirements
- R1: While reset is asserted and immediately after it is released, the memory address is 0x3000, write enable is low and halted is low. The first instruction is fetched from 0x3000, and the condition code starts with only Z set.
- R2: ADD (opcode 0x1) writes SR1 plus SR2 (bits 2:0) into DR (bits 11:9) when bit 5 is 0. When bit 5 is 1 it adds the sign-extended imm5 (bits 4:0) instead. SR1 is in bits 8:6.
- R3: AND (opcode 0x5) writes the bitwise AND of SR1 and SR2 into DR. When bit 5 is 1 it uses the zero-extended imm5 instead of SR2.
- R4: NOT (opcode 0x9) writes the bitwise complement of SR1 into DR.
- R5: Only ADD, AND and NOT update the condition code. Exactly one of N, Z or P is set, according to the sign of the result written. Loads, LEA, stores, jumps and traps leave the condition code unchanged.
- R6: LD (0x2), ST (0x3), LEA (0xE), BR and JSR use the effective address {PC+1 [15:9], ir[8:0]}. Here PC+1 is the address after the instruction word, so a page crossing caused by the increment is honoured. LEA writes this address into DR.
- R7: BR (opcode 0x0) jumps when any of ir[11] (N), ir[10] (Z) or ir[9] (P) matches a set flag. With no bits set it never jumps, and with all three set it always jumps.
- R8: LDI (0xA) and STI (0xB) read a pointer from the page address, then load DR from, or store SR (bits 11:9) to, the address held in that pointer.
- R9: LDR (0x6), STR (0x7) and JSRR (0xC) use base register (bits 8:6) plus the zero-extended offset6 (bits 5:0).
- R10: JSR (0x4) and JSRR write the incremented PC into R7 only when ir[11] is 1. The target is computed from register values read before the link is written. RET is encoded as opcode 0xC with ir[11]=0, base R7 and offset 0.
- R11: TRAP (opcode 0xF, vector in bits 7:0) writes the incremented PC into R7. It then loads the PC with the word at address {8'h00, vector}.
- R12: TRAP with vector 0x25 raises halted. From then until reset the core performs no memory writes and the memory address stays constant.
- R13: Memory writes occur only for ST, STR and STI. Opcodes 0x8 and 0xD do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| mem_we_o | output | 1 | Memory write enable |
| halted_o | output | 1 | High once the stop trap has executed |

## Verification
The hardest situation to reach from the ports is a page-addressed instruction placed in the last word of a page. In that case the incremented PC, not the instruction's own address, must supply the page bits. The stimulus reaches it with a linked JSRR whose base register is loaded from a data word, so that it lands on address 0x35FF. An LEA sits there, and a following STR exposes the result at the memory port, after which RET returns. Indirect accesses, trap vectoring and the non-linking JSR are observed the same way: each intermediate register is stored to a result area and compared against a behavioural instruction-level model, write by write.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  typedef enum logic [3:0] {
    OP_BR   = 4'h0, OP_ADD  = 4'h1, OP_LD   = 4'h2, OP_ST   = 4'h3,
    OP_JSR  = 4'h4, OP_AND  = 4'h5, OP_LDR  = 4'h6, OP_STR  = 4'h7,
    OP_RTI  = 4'h8, OP_NOT  = 4'h9, OP_LDI  = 4'hA, OP_STI  = 4'hB,
    OP_JSRR = 4'hC, OP_RSV  = 4'hD, OP_LEA  = 4'hE, OP_TRAP = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_IND, ST_ACC, ST_LOAD, ST_HALT
  } state_e;

  localparam int unsigned DW      = 16;
  localparam int unsigned PAGE_W  = 9;
  localparam int unsigned OFF_W   = 6;
  localparam int unsigned IMM_W   = 5;
  localparam int unsigned VEC_W   = 8;
endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs[g] <= '0;
      else if (we_i && waddr_i == AW'(g))        regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  opcode_e           op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  output logic [DW-1:0]     res_o,
  output logic [2:0]        nzp_o
);
  logic [DW-1:0] add_b, and_b;

  assign add_b = imm_sel_i ? {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i} : b_i;
  assign and_b = imm_sel_i ? {{(DW-IMM_W){1'b0}}, imm_i} : b_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + add_b;
      OP_AND:  res_o = a_i & and_b;
      default: res_o = ~a_i;
    endcase
  end

  assign nzp_o = {res_o[DW-1], res_o == '0, !res_o[DW-1] && res_o != '0};
endmodule

// File: rtl/cpu16_agen.sv
module cpu16_agen
  import cpu16_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] ir_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] page_ea_o,
  output logic [DW-1:0] base_ea_o
);
  // page bits come straight from the incremented PC; no adder
  assign page_ea_o = {pc_i[DW-1:PAGE_W], ir_i[PAGE_W-1:0]};
  assign base_ea_o = base_i + {{(DW-OFF_W){1'b0}}, ir_i[OFF_W-1:0]};
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h3000,
  parameter logic [7:0]  HALT_VEC = 8'h25,
  parameter int unsigned NREG     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] mem_addr_o,
  output logic [15:0] mem_wdata_o,
  input  logic [15:0] mem_rdata_i,
  output logic        mem_we_o,
  output logic        halted_o
);
  localparam int unsigned RAW  = $clog2(NREG);
  localparam logic [RAW-1:0] LINK = RAW'(NREG - 1);

  state_e         state_q;
  logic [DW-1:0]  pc_q, ir_q, mar_q;
  logic [2:0]     flags_q;  // {n,z,p}

  opcode_e        op;
  logic [RAW-1:0] dr, sr1, rb_addr;
  logic [DW-1:0]  rf_a, rf_b, alu_res, page_ea, base_ea;
  logic [2:0]     alu_nzp;
  logic           rf_we;
  logic [RAW-1:0] rf_waddr;
  logic [DW-1:0]  rf_wdata;
  logic           is_store, br_take, halt_trap;

  assign op        = opcode_e'(ir_q[15:12]);
  assign dr        = RAW'(ir_q[11:9]);
  assign sr1       = RAW'(ir_q[8:6]);
  assign is_store  = op inside {OP_ST, OP_STR, OP_STI};
  assign rb_addr   = is_store ? dr : RAW'(ir_q[2:0]);
  assign br_take   = |(ir_q[11:9] & flags_q);
  assign halt_trap = ir_q[VEC_W-1:0] == HALT_VEC;

  cpu16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .raddr_a_i(sr1), .rdata_a_o(rf_a),
    .raddr_b_i(rb_addr), .rdata_b_o(rf_b)
  );

  cpu16_alu #(.DW(DW)) u_alu (
    .op_i(op), .a_i(rf_a), .b_i(rf_b), .imm_i(ir_q[IMM_W-1:0]),
    .imm_sel_i(ir_q[5]), .res_o(alu_res), .nzp_o(alu_nzp)
  );

  cpu16_agen #(.DW(DW)) u_agen (
    .ir_i(ir_q), .pc_i(pc_q), .base_i(rf_a),
    .page_ea_o(page_ea), .base_ea_o(base_ea)
  );

  always_comb begin
    unique case (state_q)
      ST_EXEC: begin
        if (op == OP_TRAP)                 mem_addr_o = {{(DW-VEC_W){1'b0}}, ir_q[VEC_W-1:0]};
        else if (op inside {OP_LDR, OP_STR}) mem_addr_o = base_ea;
        else                               mem_addr_o = page_ea;
      end
      ST_ACC:  mem_addr_o = mar_q;
      default: mem_addr_o = pc_q;
    endcase
  end

  assign mem_we_o    = (state_q == ST_EXEC && op inside {OP_ST, OP_STR}) ||
                       (state_q == ST_ACC  && op == OP_STI);
  assign mem_wdata_o = rf_b;
  assign halted_o    = state_q == ST_HALT;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dr;
    rf_wdata = alu_res;
    if (state_q == ST_EXEC) begin
      unique case (op)
        OP_ADD, OP_AND, OP_NOT: rf_we = 1'b1;
        OP_LEA: begin rf_we = 1'b1; rf_wdata = page_ea; end
        OP_JSR, OP_JSRR: begin
          rf_we = ir_q[11]; rf_waddr = LINK; rf_wdata = pc_q;
        end
        OP_TRAP: begin rf_we = 1'b1; rf_waddr = LINK; rf_wdata = pc_q; end
        default: ;
      endcase
    end else if (state_q == ST_LOAD && op != OP_TRAP) begin
      rf_we    = 1'b1;
      rf_wdata = mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      mar_q   <= '0;
      flags_q <= 3'b010;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          ir_q    <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          unique case (op)
            OP_ADD, OP_AND, OP_NOT: flags_q <= alu_nzp;
            OP_BR:   if (br_take) pc_q <= page_ea;
            OP_JSR:  pc_q <= page_ea;
            OP_JSRR: pc_q <= base_ea;
            OP_LD, OP_LDR: state_q <= ST_LOAD;
            OP_LDI, OP_STI: state_q <= ST_IND;
            OP_TRAP: state_q <= halt_trap ? ST_HALT : ST_LOAD;
            default: ;
          endcase
        end
        ST_IND: begin
          mar_q   <= mem_rdata_i;
          state_q <= ST_ACC;
        end
        ST_ACC:  state_q <= (op == OP_LDI) ? ST_LOAD : ST_FETCH;
        ST_LOAD: begin
          if (op == OP_TRAP) pc_q <= mem_rdata_i;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input state_e      state_i,
  input logic [15:0] pc_i,
  input logic [15:0] ir_i,
  input logic [2:0]  flags_i,
  input logic [15:0] mem_addr_i,
  input logic [15:0] mem_rdata_i,
  input logic        mem_we_i,
  input logic        halted_i
);
  opcode_e op;
  logic    alu_op;
  assign op     = opcode_e'(ir_i[15:12]);
  assign alu_op = op inside {OP_ADD, OP_AND, OP_NOT};

  AST_FLAGS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_i) == 1);                                            // R5
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_i == ST_EXEC && alu_op) |=> $stable(flags_i));                // R5
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |=> pc_i == $past(pc_i) + 16'd1);               // R6
  AST_PTR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACC) |-> mem_addr_i == $past(mem_rdata_i));            // R8
  AST_TRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXEC && op == OP_TRAP) |-> mem_addr_i[15:8] == 8'h00); // R11
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);                                               // R12
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i);                                              // R12
  AST_HALT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(mem_addr_i));                                    // R12
  AST_WE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> op inside {OP_ST, OP_STR, OP_STI});                      // R13
endmodule

bind cpu16_core cpu16_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q), .pc_i(pc_q),
  .ir_i(ir_q), .flags_i(flags_q), .mem_addr_i(mem_addr_o),
  .mem_rdata_i(mem_rdata_i), .mem_we_i(mem_we_o), .halted_i(halted_o)
);

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, halted;

  always #10 clk = ~clk;

  cpu16_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .halted_o(halted)
  );

  logic [15:0] prog [int];
  logic [15:0] dmem [int];
  logic [15:0] rmem [int];
  string       tag_of [int];
  logic [31:0] exp_q [$];
  int n_chk = 0, n_fail = 0;
  int wp, k;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // synchronous memory: data one cycle after address
  always @(posedge clk) begin
    mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 16'h0000;
    if (mem_we === 1'b1) dmem[int'(mem_addr)] = mem_wdata;
  end

  // every write compared against the model's store stream
  always @(negedge clk) begin
    if (rst_ni === 1'b1 && mem_we === 1'b1) begin
      string t;
      logic [31:0] e;
      t = tag_of.exists(int'(mem_addr)) ? tag_of[int'(mem_addr)] : "R13";
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL %s unexpected store: actual %h expected none", t, {mem_addr, mem_wdata});
      end else begin
        e = exp_q.pop_front();
        chk(t, {mem_addr, mem_wdata}, e, "store");
      end
    end
  end

  function automatic logic [15:0] rrd(logic [15:0] a);
    return rmem.exists(int'(a)) ? rmem[int'(a)] : 16'h0000;
  endfunction

  task automatic rwr(logic [15:0] a, logic [15:0] d);
    rmem[int'(a)] = d;
    exp_q.push_back({a, d});
  endtask

  // instruction-level reference model
  task automatic run_iss();
    logic [15:0] r [8];
    logic [15:0] pc, ir, pg, be, v, t;
    logic n, z, p;
    bit stop;
    foreach (r[i]) r[i] = 16'h0;
    pc = 16'h3000; n = 0; z = 1; p = 0; stop = 0;
    for (int step = 0; step < 5000 && !stop; step++) begin
      ir = rrd(pc);
      pc = pc + 16'd1;
      pg = {pc[15:9], ir[8:0]};
      be = r[ir[8:6]] + {10'h000, ir[5:0]};
      case (ir[15:12])
        4'h1, 4'h5, 4'h9: begin
          if (ir[15:12] == 4'h1)
            v = r[ir[8:6]] + (ir[5] ? {{11{ir[4]}}, ir[4:0]} : r[ir[2:0]]);
          else if (ir[15:12] == 4'h5)
            v = r[ir[8:6]] & (ir[5] ? {11'h000, ir[4:0]} : r[ir[2:0]]);
          else
            v = ~r[ir[8:6]];
          r[ir[11:9]] = v;
          n = v[15]; z = (v == 0); p = !v[15] && v != 0;
        end
        4'h0: if ((ir[11] && n) || (ir[10] && z) || (ir[9] && p)) pc = pg;
        4'h2: r[ir[11:9]] = rrd(pg);
        4'h3: rwr(pg, r[ir[11:9]]);
        4'h6: r[ir[11:9]] = rrd(be);
        4'h7: rwr(be, r[ir[11:9]]);
        4'hA: r[ir[11:9]] = rrd(rrd(pg));
        4'hB: rwr(rrd(pg), r[ir[11:9]]);
        4'hE: r[ir[11:9]] = pg;
        4'h4, 4'hC: begin
          t = (ir[15:12] == 4'h4) ? pg : be;
          if (ir[11]) r[7] = pc;
          pc = t;
        end
        4'hF: begin
          r[7] = pc;
          if (ir[7:0] == 8'h25) stop = 1;
          else pc = rrd({8'h00, ir[7:0]});
        end
        default: ;
      endcase
    end
  endtask

  task automatic em(logic [15:0] w);
    prog[wp] = w;
    wp++;
  endtask

  task automatic put(logic [2:0] rg, string t);
    tag_of[32'h3180 + k] = t;
    em({4'h3, rg, 9'(384 + k)});
    k++;
  endtask

  task automatic br_skip(logic [2:0] nzp);
    em({4'h0, nzp, 9'(wp + 2)});
  endtask

  task automatic build();
    int ret_pt;
    wp = 32'h3000; k = 0;
    em({4'h2, 3'd0, 9'h100});                   put(3'd0, "R6");
    em({4'h2, 3'd1, 9'h101});
    em({4'h1, 3'd2, 3'd0, 3'b000, 3'd1});       put(3'd2, "R2");
    em({4'h1, 3'd3, 3'd0, 1'b1, 5'h1F});        put(3'd3, "R2");
    em({4'h5, 3'd4, 3'd1, 1'b1, 5'h1F});        put(3'd4, "R3");
    em({4'h5, 3'd5, 3'd0, 3'b000, 3'd1});       put(3'd5, "R3");
    em({4'h9, 3'd6, 3'd0, 6'h3F});              put(3'd6, "R4");
    em({4'h2, 3'd5, 9'h100});
    br_skip(3'b100); em({4'h1, 3'd5, 3'd5, 1'b1, 5'd1}); put(3'd5, "R5");
    br_skip(3'b000); em({4'h1, 3'd5, 3'd5, 1'b1, 5'd1}); put(3'd5, "R7");
    br_skip(3'b010); em({4'h1, 3'd5, 3'd5, 1'b1, 5'd1});
    br_skip(3'b001); em({4'h1, 3'd5, 3'd5, 1'b1, 5'd1}); put(3'd5, "R7");
    em({4'h5, 3'd4, 3'd4, 1'b1, 5'd0});
    br_skip(3'b111); em({4'h1, 3'd4, 3'd4, 1'b1, 5'd1});
    br_skip(3'b101); em({4'h1, 3'd4, 3'd4, 1'b1, 5'd2}); put(3'd4, "R7");
    em({4'hE, 3'd3, 9'h150});                   put(3'd3, "R6");
    em({4'hA, 3'd2, 9'h102});                   put(3'd2, "R8");
    em({4'hB, 3'd6, 9'h103});                   tag_of[32'h4010] = "R8";
    em({4'h2, 3'd1, 9'h102});
    em({4'h6, 3'd3, 3'd1, 6'd5});               put(3'd3, "R9");
    em({4'h7, 3'd3, 3'd1, 6'd63});              tag_of[32'h403F] = "R9";
    em({4'h4, 1'b1, 2'b00, 9'h160});            put(3'd7, "R10"); put(3'd0, "R10");
    ret_pt = wp + 1;
    em({4'h4, 1'b0, 2'b00, 9'h170});            put(3'd7, "R10"); put(3'd0, "R10");
    em({4'h2, 3'd1, 9'h104});
    em({4'hC, 1'b1, 2'b00, 3'd1, 6'd1});        put(3'd7, "R10");
    em({4'hF, 4'h0, 8'h20});                    put(3'd7, "R11"); put(3'd4, "R11");
    em({4'hF, 4'h0, 8'h25});                    put(3'd0, "R12");
    // data
    prog[32'h3100] = 16'h1234; prog[32'h3101] = 16'h8001;
    prog[32'h3102] = 16'h4000; prog[32'h3103] = 16'h4010;
    prog[32'h3104] = 16'h35FE;
    prog[32'h4000] = 16'hBEEF; prog[32'h4005] = 16'h0777;
    prog[32'h0020] = 16'h0400;
    // subroutines
    prog[32'h3160] = {4'h1, 3'd0, 3'd0, 1'b1, 5'd1};
    prog[32'h3161] = {4'hC, 1'b0, 2'b00, 3'd7, 6'd0};
    prog[32'h3170] = {4'h1, 3'd0, 3'd0, 1'b1, 5'd2};
    prog[32'h3171] = {4'h0, 3'b111, 9'(ret_pt)};
    // last word of a page: LEA sees the next page
    prog[32'h35FF] = {4'hE, 3'd2, 9'h005};
    prog[32'h3600] = {4'h7, 3'd2, 3'd1, 6'd10};  tag_of[32'h3608] = "R6";
    prog[32'h3601] = {4'hC, 1'b0, 2'b00, 3'd7, 6'd0};
    // trap handler
    prog[32'h0400] = {4'h1, 3'd4, 3'd4, 1'b1, 5'd5};
    prog[32'h0401] = {4'hC, 1'b0, 2'b00, 3'd7, 6'd0};
  endtask

  initial begin
    logic [15:0] a0;
    int cyc;
    build();
    foreach (prog[a]) begin dmem[a] = prog[a]; rmem[a] = prog[a]; end
    run_iss();
    repeat (3) @(negedge clk);
    chk("R1", {15'h0, mem_we}, 32'h0, "we in reset");
    rst_ni = 1'b1;
    #1;
    chk("R1", {16'h0, mem_addr}, 32'h3000, "first fetch address");
    chk("R1", {31'h0, halted}, 32'h0, "halted after reset");
    cyc = 0;
    while (halted !== 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12", {31'h0, halted}, 32'h1, "halted (watchdog)");
    chk("R12", exp_q.size(), 32'h0, "stores outstanding");
    a0 = mem_addr;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R12", {31'h0, halted}, 32'h1, "halted held");
      chk("R12", {16'h0, mem_addr}, {16'h0, a0}, "address frozen");
      chk("R12", {31'h0, mem_we}, 32'h0, "no write after halt");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule